// File: doc/BRIEF.md
# Descriptor Ring Address Stepper

This block supplies the current descriptor address for the transmit ring and the receive ring of an Ethernet MAC's DMA engine. One 32-bit DMA control word, loaded through a small register write port, holds a descriptor-size field for each direction. The size is counted in 8-byte units, so software can leave spare room after the fixed 16-byte descriptor layout. The same word also keeps burst-length and inter-frame-gap settings. Those settings are only stored and read back. Each ring also has a base address register.

When the DMA engine is done with a descriptor, it pulses that ring's advance strobe and presents the descriptor's end-of-ring bit. The ring pointer then either steps forward by the configured stride or returns to the ring base. If a control-word write leaves a descriptor size below the 16-byte minimum, a sticky error flag for that direction is raised.

Top module: `desc_ring_stepper`

## Requirements
- R1: After a synchronous reset, `ctrl_rd` reads 0x00022500, both ring pointers read 0 and both size error flags read 0.
- R2: A write with `wr_sel`=0 stores bits 23:8 of `wr_data` into the control word. `ctrl_rd` returns those bits and reads 0 in bits 31:24 and 7:0.
- R3: The receive stride is bits 15:12 of the control word times 8 bytes. The transmit stride is bits 19:16 times 8 bytes.
- R4: An advance strobe with the end-of-ring bit clear sets that ring's pointer to the old pointer plus its stride, modulo 2^32, on the next clock.
- R5: An advance strobe with the end-of-ring bit set loads that ring's base address into its pointer.
- R6: A write with `wr_sel`=1 (transmit) or `wr_sel`=2 (receive) loads both the ring base and the ring pointer. If it coincides with an advance of the same ring, the write wins.
- R7: The rings are independent. Advancing, wrapping or rebasing one ring never changes the other ring's pointer.
- R8: On each control write, a direction's error flag is set when its new size field is below 2 (under 16 bytes) and cleared otherwise. Between control writes, the flag holds its value.
- R9: The burst fields (bits 11:8), the gap count (bits 22:20) and the gap increment bit (23) have no effect on either stride.
- R10: Without an advance strobe or a base write, a ring pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control word, 1 transmit base, 2 receive base |
| wr_data | input | 32 | Write data |
| tx_adv | input | 1 | Transmit descriptor done pulse |
| tx_eor | input | 1 | End-of-ring bit of that transmit descriptor |
| rx_adv | input | 1 | Receive descriptor done pulse |
| rx_eor | input | 1 | End-of-ring bit of that receive descriptor |
| ctrl_rd | output | 32 | Control word readback |
| tx_addr | output | 32 | Current transmit descriptor address |
| rx_addr | output | 32 | Current receive descriptor address |
| tx_size_err | output | 1 | Sticky flag: transmit descriptor size too small |
| rx_size_err | output | 1 | Sticky flag: receive descriptor size too small |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 4-bit size fields and an 8-byte unit. With these values the full stride range (0 to 120 bytes) can be reached with a few writes. A base just below 2^32 reaches the modulo wrap of the pointer in one step. The stimulus table moves both rings through default, widened and narrowed strides and through end-of-ring wraps. Directed cases cover reset, field masking, error-flag set and clear, a coinciding base write and advance, and wrap-around at the top of the address space.

// File: rtl/ring_step_pkg.sv
package ring_step_pkg;
  localparam int ADDR_W     = 32;
  localparam int SIZE_W     = 4;
  localparam int UNIT_SHIFT = 3;   // stride unit is 8 bytes
  localparam int MIN_SIZE   = 2;   // 16-byte minimum descriptor
  localparam int RX_SIZE_LO = 12;
  localparam int TX_SIZE_LO = 16;
  localparam logic [31:0] CTRL_MASK  = 32'h00FF_FF00;
  localparam logic [31:0] CTRL_RESET = 32'h0002_2500;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_TXB  = 2'd1,
    SEL_RXB  = 2'd2
  } wsel_e;
endpackage

// File: rtl/ring_ctrl_reg.sv
module ring_ctrl_reg
  import ring_step_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SW = SIZE_W,
  parameter int SH = UNIT_SHIFT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [31:0]   din,
  output logic [31:0]   word,
  output logic [AW-1:0] tx_stride,
  output logic [AW-1:0] rx_stride,
  output logic          tx_err,
  output logic          rx_err
);
  logic [31:0]   word_q;
  logic [SW-1:0] tx_sz, rx_sz, tx_sz_n, rx_sz_n;

  assign tx_sz   = word_q[TX_SIZE_LO +: SW];
  assign rx_sz   = word_q[RX_SIZE_LO +: SW];
  assign tx_sz_n = din[TX_SIZE_LO +: SW];
  assign rx_sz_n = din[RX_SIZE_LO +: SW];

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= CTRL_RESET;
      tx_err <= 1'b0;
      rx_err <= 1'b0;
    end else if (we) begin
      word_q <= din & CTRL_MASK;
      tx_err <= (tx_sz_n < SW'(MIN_SIZE));
      rx_err <= (rx_sz_n < SW'(MIN_SIZE));
    end
  end

  assign word      = word_q;
  assign tx_stride = AW'(tx_sz) << SH;
  assign rx_stride = AW'(rx_sz) << SH;

  AST_ERR_TX_SET: assert property (@(posedge clk) disable iff (rst)
    we && (din[TX_SIZE_LO +: SW] < SW'(MIN_SIZE)) |=> tx_err); // R8
  AST_ERR_RX_CLR: assert property (@(posedge clk) disable iff (rst)
    we && (din[RX_SIZE_LO +: SW] >= SW'(MIN_SIZE)) |=> !rx_err); // R8
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(tx_err) && $stable(rx_err)); // R8
  AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (rst)
    we |=> (word & ~CTRL_MASK) == 32'h0); // R2
endmodule

// File: rtl/ring_ptr_unit.sv
module ring_ptr_unit
  import ring_step_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_we,
  input  logic [AW-1:0] base_d,
  input  logic          adv,
  input  logic          eor,
  input  logic [AW-1:0] stride,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      ptr    <= '0;
    end else if (base_we) begin
      base_q <= base_d;
      ptr    <= base_d;
    end else if (adv) begin
      ptr <= eor ? base_q : ptr + stride;
    end
  end

  AST_STEP_FWD: assert property (@(posedge clk) disable iff (rst)
    adv && !eor && !base_we |=> ptr == $past(ptr) + $past(stride)); // R4
  AST_EOR_WRAP: assert property (@(posedge clk) disable iff (rst)
    adv && eor && !base_we |=> ptr == $past(base_q)); // R5
  AST_BASE_WINS: assert property (@(posedge clk) disable iff (rst)
    base_we |=> ptr == $past(base_d)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv && !base_we |=> $stable(ptr)); // R10
endmodule

// File: rtl/desc_ring_stepper.sv
module desc_ring_stepper
  import ring_step_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic        tx_adv,
  input  logic        tx_eor,
  input  logic        rx_adv,
  input  logic        rx_eor,
  output logic [31:0] ctrl_rd,
  output logic [31:0] tx_addr,
  output logic [31:0] rx_addr,
  output logic        tx_size_err,
  output logic        rx_size_err
);
  localparam int NRING = 2;   // index 0 transmit, 1 receive

  logic [ADDR_W-1:0] stride_v [NRING];
  logic [ADDR_W-1:0] ptr_v    [NRING];
  logic              adv_v    [NRING];
  logic              eor_v    [NRING];
  logic              bwe_v    [NRING];

  assign adv_v[0] = tx_adv;
  assign adv_v[1] = rx_adv;
  assign eor_v[0] = tx_eor;
  assign eor_v[1] = rx_eor;
  assign bwe_v[0] = wr_en && (wr_sel == SEL_TXB);
  assign bwe_v[1] = wr_en && (wr_sel == SEL_RXB);

  ring_ctrl_reg #(.AW(ADDR_W), .SW(SIZE_W), .SH(UNIT_SHIFT)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .we        (wr_en && (wr_sel == SEL_CTRL)),
    .din       (wr_data),
    .word      (ctrl_rd),
    .tx_stride (stride_v[0]),
    .rx_stride (stride_v[1]),
    .tx_err    (tx_size_err),
    .rx_err    (rx_size_err)
  );

  for (genvar g = 0; g < NRING; g++) begin : g_ring
    ring_ptr_unit #(.AW(ADDR_W)) u_ptr (
      .clk     (clk),
      .rst     (rst),
      .base_we (bwe_v[g]),
      .base_d  (wr_data[ADDR_W-1:0]),
      .adv     (adv_v[g]),
      .eor     (eor_v[g]),
      .stride  (stride_v[g]),
      .ptr     (ptr_v[g])
    );
  end

  assign tx_addr = ptr_v[0];
  assign rx_addr = ptr_v[1];

  AST_RX_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    !rx_adv && !(wr_en && wr_sel == SEL_RXB) |=> $stable(rx_addr)); // R7
  AST_TX_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    !tx_adv && !(wr_en && wr_sel == SEL_TXB) |=> $stable(tx_addr)); // R7
endmodule

// File: tb/desc_ring_stepper_test.sv
module desc_ring_stepper_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  // op: 0 ctrl write, 1 tx base, 2 rx base, 3 tx adv, 4 tx adv+eor,
  //     5 rx adv, 6 rx adv+eor, 7 both adv
  // entry: {op[2:0], data[31:0], exp_tx[31:0], exp_rx[31:0]}
  localparam logic [98:0] VEC [NVEC] = '{
    {3'd1, 32'h0000_1000, 32'h0000_1000, 32'h0000_0000},
    {3'd2, 32'h0000_2000, 32'h0000_1000, 32'h0000_2000},
    {3'd3, 32'h0,         32'h0000_1010, 32'h0000_2000},
    {3'd3, 32'h0,         32'h0000_1020, 32'h0000_2000},
    {3'd5, 32'h0,         32'h0000_1020, 32'h0000_2010},
    {3'd0, 32'h0004_4F97, 32'h0000_1020, 32'h0000_2010},
    {3'd3, 32'h0,         32'h0000_1040, 32'h0000_2010},
    {3'd5, 32'h0,         32'h0000_1040, 32'h0000_2030},
    {3'd7, 32'h0,         32'h0000_1060, 32'h0000_2050},
    {3'd4, 32'h0,         32'h0000_1000, 32'h0000_2050},
    {3'd6, 32'h0,         32'h0000_1000, 32'h0000_2000},
    {3'd0, 32'h00F3_1F00, 32'h0000_1000, 32'h0000_2000},
    {3'd3, 32'h0,         32'h0000_1018, 32'h0000_2000},
    {3'd5, 32'h0,         32'h0000_1018, 32'h0000_2008}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, tx_adv, tx_eor, rx_adv, rx_eor;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [31:0] ctrl_rd, tx_addr, rx_addr;
  logic        tx_size_err, rx_size_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_ring_stepper uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tx_adv(tx_adv), .tx_eor(tx_eor), .rx_adv(rx_adv), .rx_eor(rx_eor),
    .ctrl_rd(ctrl_rd), .tx_addr(tx_addr), .rx_addr(rx_addr),
    .tx_size_err(tx_size_err), .rx_size_err(rx_size_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_sel = 0; wr_data = 0;
    tx_adv = 0; tx_eor = 0; rx_adv = 0; rx_eor = 0;
  endtask

  // drive at a falling edge, let one rising edge pass, release at next falling edge
  task automatic apply(input logic [2:0] op, input logic [31:0] d);
    @(negedge clk);
    idle_inputs();
    case (op)
      3'd0: begin wr_en = 1; wr_sel = 2'd0; wr_data = d; end
      3'd1: begin wr_en = 1; wr_sel = 2'd1; wr_data = d; end
      3'd2: begin wr_en = 1; wr_sel = 2'd2; wr_data = d; end
      3'd3: tx_adv = 1;
      3'd4: begin tx_adv = 1; tx_eor = 1; end
      3'd5: rx_adv = 1;
      3'd6: begin rx_adv = 1; rx_eor = 1; end
      default: begin tx_adv = 1; rx_adv = 1; end
    endcase
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 ctrl", ctrl_rd, 32'h0002_2500);
    chk("R1 tx_addr", tx_addr, 32'h0);
    chk("R1 rx_addr", rx_addr, 32'h0);
    chk("R1 errs", {30'h0, tx_size_err, rx_size_err}, 32'h0);

    // table walk: R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][98:96], VEC[i][95:64]);
      chk("R4/R5/R7 tx", tx_addr, VEC[i][63:32]);
      chk("R4/R5/R7 rx", rx_addr, VEC[i][31:0]);
    end
    // after entry 11: tx size 3, rx size 1
    chk("R8 rx err set", {31'h0, rx_size_err}, 32'h1);
    chk("R8 tx err clear", {31'h0, tx_size_err}, 32'h0);
    chk("R2 masked readback", ctrl_rd, 32'h00F3_1F00);

    // R10 pointer holds while idle, R8 flag holds
    repeat (4) @(negedge clk);
    chk("R10 tx hold", tx_addr, 32'h0000_1018);
    chk("R10 rx hold", rx_addr, 32'h0000_2008);
    chk("R8 rx err sticky", {31'h0, rx_size_err}, 32'h1);

    // R2 masking of low and high bytes
    apply(3'd0, 32'hFF00_20FF);
    chk("R2 mask", ctrl_rd, 32'h0000_2000);
    chk("R8 tx err on size 0", {31'h0, tx_size_err}, 32'h1);
    chk("R8 rx err cleared", {31'h0, rx_size_err}, 32'h0);

    // R9: burst and gap fields changed, sizes 2/2 -> stride 16
    apply(3'd0, 32'h00F2_2F00);
    chk("R8 both clear", {30'h0, tx_size_err, rx_size_err}, 32'h0);
    apply(3'd1, 32'h0000_3000);
    apply(3'd3, 32'h0);
    chk("R9 tx stride 16", tx_addr, 32'h0000_3010);
    apply(3'd2, 32'h0000_4000);
    apply(3'd5, 32'h0);
    chk("R9 rx stride 16", rx_addr, 32'h0000_4010);

    // R3: largest size 15 -> 120 bytes on tx, rx size 1 -> 8 bytes
    apply(3'd0, 32'h000F_1000);
    apply(3'd3, 32'h0);
    chk("R3 tx stride 120", tx_addr, 32'h0000_3088);
    apply(3'd5, 32'h0);
    chk("R3 rx stride 8", rx_addr, 32'h0000_4018);

    // R4 modulo wrap at top of address space
    apply(3'd0, 32'h0002_2500);
    apply(3'd1, 32'hFFFF_FFF0);
    apply(3'd3, 32'h0);
    chk("R4 modulo wrap", tx_addr, 32'h0000_0000);
    apply(3'd4, 32'h0);
    chk("R5 eor back to base", tx_addr, 32'hFFFF_FFF0);

    // R6 base write wins over coinciding advance
    @(negedge clk);
    idle_inputs();
    wr_en = 1; wr_sel = 2'd2; wr_data = 32'h0000_5000; rx_adv = 1;
    @(negedge clk);
    idle_inputs();
    chk("R6 rx base wins", rx_addr, 32'h0000_5000);
    chk("R7 tx untouched", tx_addr, 32'hFFFF_FFF0);
    apply(3'd6, 32'h0);
    chk("R6 base register loaded", rx_addr, 32'h0000_5000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule